// File: doc/BRIEF.md
# NAND Bus Phase Timing Sequencer

This block drives one asynchronous NAND flash bus cycle per request: a command byte, an address byte, a data write or a data read. Each cycle is made of programmable phases. A setup phase asserts chip enable and the latch strobes. A strobe phase holds WE# or RE# low. A hold phase keeps the bus stable after the strobe rises. Two extra phases exist for reads only. A high-impedance turnaround phase runs when the bus changes from driving to receiving. A latch-to-read delay runs when a read directly follows a command or address cycle.

Phase counts come from one packed 32-bit timing word. A control word holds the bank enable, the device-type select, the bus width, the ready-input enable and the two 4-bit latch-to-read delays. The timing and control fields are sampled when a request is accepted. The enable and device-type bits act at all times. The host raises `req_valid` while `busy` is low. The block pulses `done` when the cycle ends, and read data is then available on `rd_data`.

Top module: `nand_phase_seq`

## Requirements
- R1: Timing word fields are setup = bits 7:0, strobe = bits 15:8, hold = bits 23:16 and turnaround = bits 31:24. The setup phase lasts setup+1 clocks. The strobe phase lasts strobe+1 clocks. WE# is low for the whole strobe phase of command, address and write cycles, and RE# is low for the whole strobe phase of read cycles. WE# and RE# are never low at the same time.
- R2: The hold phase lasts exactly hold clocks. CE# is low in every phase of a cycle and high whenever the block is idle. After reset the block is idle: CE#, WE# and RE# are high, and CLE, ALE, `dq_oe`, `busy` and `done` are low.
- R3: A setup, strobe or hold count of zero behaves exactly like a count of 1.
- R4: Command cycles hold CLE high through setup, strobe and hold. Address cycles do the same with ALE. Data cycles raise neither. Command and address cycles drive only the low byte on `dq_out`, with the upper byte zero. `req_type` codes are 0 = command, 1 = address, 2 = write and 3 = read.
- R5: Control bit 4 selects a 16-bit device. With it set, write cycles drive all 16 bits and reads return all 16 bits. With it clear, both use the low byte only and the upper byte is zero.
- R6: A read captures `dq_in` on the last clock of the strobe phase. The captured value is on `rd_data` when `done` pulses.
- R7: A read that directly follows a command cycle waits control bits 12:9 plus 1 clocks before its setup phase. A read that directly follows an address cycle waits control bits 16:13 plus 1 clocks. During this wait CE# is low and no other strobe is active.
- R8: The turnaround phase lasts exactly the turnaround count. It is inserted only for a read whose previous cycle was a command, address or write, and it comes before any latch-to-read wait. `dq_oe` is low and RE# is high during it. After reset, the previous direction counts as read.
- R9: `busy` is high from the clock after acceptance until the hold phase ends. `done` is a one-clock pulse in the first idle clock. A request raised while `busy` is high is ignored.
- R10: Requests are accepted only when control bit 2 (enable) and bit 3 (NAND device) are both set. Clearing either bit during a cycle returns the block to idle on the next clock with CE# high and no `done` pulse.
- R11: With control bit 1 set, the strobe phase does not end while `rdy_in` is low. With bit 1 clear, `rdy_in` is ignored.
- R12: `dq_oe` is high only during setup, strobe and hold of command, address and write cycles. `dq_out` is zero whenever `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word | input | 32 | Packed phase counts |
| ctrl_word | input | 32 | Enable, device type, width, ready enable, latch-to-read delays |
| req_valid | input | 1 | Request strobe, accepted while busy is low |
| req_type | input | 2 | 0 command, 1 address, 2 write, 3 read |
| req_data | input | 16 | Byte or word to drive |
| rdy_in | input | 1 | Device ready, high when ready |
| dq_in | input | 16 | Bus data from the device |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock pulse at cycle end |
| rd_data | output | 16 | Last captured read data |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dq_out | output | 16 | Bus data to the device |
| dq_oe | output | 1 | Bus output enable |

## Verification
The assertions check several rules on every clock:
- CE# is high whenever the block is idle, and an accepted request always raises busy.
- WE# and RE# are never low together, CLE and ALE are never high together, and the bus is never driven while RE# is low.
- A disable always returns the block to idle, and a stalled strobe phase never ends while the device is not ready.
- Setup and strobe phases never last a single clock, and `done` follows only a hold phase.

Exact phase lengths, the choice and order of the turnaround and latch-to-read waits, the sampling clock of read data, the byte masking and the dropping of requests during a cycle can only be seen in the bench's cycle-by-cycle comparison.

// File: rtl/nand_phase_pkg.sv
package nand_phase_pkg;
  localparam int WORD_W    = 32;
  localparam int CNT_W     = 8;
  localparam int GAP_W     = 4;
  localparam int BYTE_W    = 8;
  // timing word field positions
  localparam int SETUP_LSB = 0;
  localparam int STRB_LSB  = 8;
  localparam int HOLD_LSB  = 16;
  localparam int TURN_LSB  = 24;
  // control word bit positions
  localparam int CB_READY  = 1;
  localparam int CB_EN     = 2;
  localparam int CB_NAND   = 3;
  localparam int CB_WIDE   = 4;
  localparam int CLR_LSB   = 9;
  localparam int ALR_LSB   = 13;

  typedef enum logic [2:0] {
    PH_IDLE, PH_TURN, PH_GAP, PH_SETUP, PH_STRB, PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    OP_CMD = 2'd0, OP_ADDR = 2'd1, OP_WRITE = 2'd2, OP_READ = 2'd3
  } op_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup_last;
    logic [CNT_W-1:0] strb_last;
    logic [CNT_W-1:0] hold_last;
    logic [CNT_W-1:0] turn_last;
    logic             turn_on;
    logic [GAP_W-1:0] clr_last;
    logic [GAP_W-1:0] alr_last;
    logic             ready_en;
    logic             wide;
  } cfg_t;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] raw);
    return (raw == '0) ? CNT_W'(1) : raw;
  endfunction

  // Counters load "last index" = length-1 of each phase.
  function automatic cfg_t decode_cfg(input logic [WORD_W-1:0] t,
                                      input logic [WORD_W-1:0] c);
    cfg_t r;
    r.setup_last = at_least_one(t[SETUP_LSB +: CNT_W]);
    r.strb_last  = at_least_one(t[STRB_LSB +: CNT_W]);
    r.hold_last  = at_least_one(t[HOLD_LSB +: CNT_W]) - CNT_W'(1);
    r.turn_on    = (t[TURN_LSB +: CNT_W] != '0);
    r.turn_last  = t[TURN_LSB +: CNT_W] - CNT_W'(1);
    r.clr_last   = c[CLR_LSB +: GAP_W];
    r.alr_last   = c[ALR_LSB +: GAP_W];
    r.ready_en   = c[CB_READY];
    r.wide       = c[CB_WIDE];
    return r;
  endfunction

  function automatic logic bank_enabled(input logic [WORD_W-1:0] c);
    return c[CB_EN] & c[CB_NAND];
  endfunction

  function automatic logic drives_bus(input op_e op);
    return op != OP_READ;
  endfunction
endpackage

// File: rtl/nps_cfg_latch.sv
module nps_cfg_latch
  import nand_phase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] timing_word,
  input  logic [WORD_W-1:0] ctrl_word,
  output cfg_t              cfg_live,
  output cfg_t              cfg_q,
  output logic              bank_on
);
  assign cfg_live = decode_cfg(timing_word, ctrl_word);
  assign bank_on  = bank_enabled(ctrl_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (load) cfg_q <= cfg_live;
  end
endmodule

// File: rtl/nps_sequencer.sv
module nps_sequencer
  import nand_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_on,
  input  logic             accept,
  input  logic             need_turn,
  input  logic             need_gap,
  input  logic [GAP_W-1:0] gap_len_in,
  input  cfg_t             cfg_live,
  input  cfg_t             cfg_q,
  input  logic             rdy_in,
  output phase_e           phase,
  output logic             strb_exit,
  output logic             done
);
  phase_e           phase_q, phase_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             gap_q;
  logic [GAP_W-1:0] gap_len_q;
  logic             cnt_zero, ready_ok, hold_end;

  assign cnt_zero  = (cnt_q == '0);
  assign ready_ok  = !cfg_q.ready_en || rdy_in;
  assign strb_exit = (phase_q == PH_STRB) && cnt_zero && ready_ok && bank_on;
  assign hold_end  = (phase_q == PH_HOLD) && cnt_zero && bank_on;
  assign phase     = phase_q;

  always_comb begin
    phase_n = phase_q;
    cnt_n   = cnt_zero ? '0 : cnt_q - CNT_W'(1);
    unique case (phase_q)
      PH_IDLE: begin
        cnt_n = '0;
        if (accept) begin
          if (need_turn) begin
            phase_n = PH_TURN;
            cnt_n   = cfg_live.turn_last;
          end else if (need_gap) begin
            phase_n = PH_GAP;
            cnt_n   = CNT_W'(gap_len_in);
          end else begin
            phase_n = PH_SETUP;
            cnt_n   = cfg_live.setup_last;
          end
        end
      end
      PH_TURN: if (cnt_zero) begin
        if (gap_q) begin
          phase_n = PH_GAP;
          cnt_n   = CNT_W'(gap_len_q);
        end else begin
          phase_n = PH_SETUP;
          cnt_n   = cfg_q.setup_last;
        end
      end
      PH_GAP: if (cnt_zero) begin
        phase_n = PH_SETUP;
        cnt_n   = cfg_q.setup_last;
      end
      PH_SETUP: if (cnt_zero) begin
        phase_n = PH_STRB;
        cnt_n   = cfg_q.strb_last;
      end
      PH_STRB: if (cnt_zero && ready_ok) begin
        phase_n = PH_HOLD;
        cnt_n   = cfg_q.hold_last;
      end
      PH_HOLD: if (cnt_zero) phase_n = PH_IDLE;
      default: begin
        phase_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
    if (!bank_on) begin
      phase_n = PH_IDLE;
      cnt_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      gap_q     <= 1'b0;
      gap_len_q <= '0;
      done      <= 1'b0;
    end else begin
      phase_q <= phase_n;
      cnt_q   <= cnt_n;
      done    <= hold_end;
      if (accept) begin
        gap_q     <= need_gap;
        gap_len_q <= gap_len_in;
      end
    end
  end

  assert_done_after_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase_q) == PH_HOLD);
  assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_on |=> phase_q == PH_IDLE);
  assert_setup_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_SETUP && $past(phase_q) != PH_SETUP)
      |=> (phase_q == PH_SETUP || phase_q == PH_IDLE));
  assert_strobe_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STRB && $past(phase_q) != PH_STRB)
      |=> (phase_q == PH_STRB || phase_q == PH_IDLE));
  assert_ready_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STRB && cfg_q.ready_en && !rdy_in)
      |=> (phase_q == PH_STRB || phase_q == PH_IDLE));
endmodule

// File: rtl/nps_bus_drive.sv
module nps_bus_drive
  import nand_phase_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  op_e               op_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              wide_in,
  input  phase_e            phase,
  input  logic              strb_exit,
  input  logic [DATA_W-1:0] dq_in,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam int UPPER_W = DATA_W - BYTE_W;

  op_e               op_q;
  logic [DATA_W-1:0] data_q;
  logic              wide_q;
  logic              latch_window, strobe_on;
  logic [DATA_W-1:0] out_word;

  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] w,
                                               input logic keep_all);
    return keep_all ? w : {{UPPER_W{1'b0}}, w[BYTE_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_CMD;
      data_q <= '0;
      wide_q <= 1'b0;
    end else if (accept) begin
      op_q   <= op_in;
      data_q <= data_in;
      wide_q <= wide_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (strb_exit && op_q == OP_READ) rd_data <= narrow(dq_in, wide_q);
  end

  assign latch_window = (phase == PH_SETUP) || (phase == PH_STRB) || (phase == PH_HOLD);
  assign strobe_on    = (phase == PH_STRB);
  assign out_word     = narrow(data_q, wide_q && op_q == OP_WRITE);

  assign ce_n   = (phase == PH_IDLE);
  assign cle    = latch_window && op_q == OP_CMD;
  assign ale    = latch_window && op_q == OP_ADDR;
  assign we_n   = !(strobe_on && drives_bus(op_q));
  assign re_n   = !(strobe_on && !drives_bus(op_q));
  assign dq_oe  = latch_window && drives_bus(op_q);
  assign dq_out = dq_oe ? out_word : '0;

  assert_latch_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_phase_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_word,
  input  logic [31:0]       ctrl_word,
  input  logic              req_valid,
  input  logic [1:0]        req_type,
  input  logic [DATA_W-1:0] req_data,
  input  logic              rdy_in,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  cfg_t             cfg_live, cfg_q;
  logic             bank_on, accept, need_turn, need_gap, strb_exit;
  logic [GAP_W-1:0] gap_len;
  phase_e           phase;
  op_e              op_in;
  logic             last_wr_q, last_cmd_q, last_addr_q;

  assign op_in     = op_e'(req_type);
  assign busy      = (phase != PH_IDLE);
  assign accept    = req_valid && !busy && bank_on;
  assign need_turn = (op_in == OP_READ) && last_wr_q && cfg_live.turn_on;
  assign need_gap  = (op_in == OP_READ) && (last_cmd_q || last_addr_q);
  assign gap_len   = last_addr_q ? cfg_live.alr_last : cfg_live.clr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_wr_q   <= 1'b0;
      last_cmd_q  <= 1'b0;
      last_addr_q <= 1'b0;
    end else if (accept) begin
      last_wr_q   <= drives_bus(op_in);
      last_cmd_q  <= (op_in == OP_CMD);
      last_addr_q <= (op_in == OP_ADDR);
    end
  end

  nps_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .timing_word(timing_word), .ctrl_word(ctrl_word),
    .cfg_live(cfg_live), .cfg_q(cfg_q), .bank_on(bank_on)
  );

  nps_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .bank_on(bank_on), .accept(accept),
    .need_turn(need_turn), .need_gap(need_gap), .gap_len_in(gap_len),
    .cfg_live(cfg_live), .cfg_q(cfg_q), .rdy_in(rdy_in),
    .phase(phase), .strb_exit(strb_exit), .done(done)
  );

  nps_bus_drive #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .accept(accept), .op_in(op_in),
    .data_in(req_data), .wide_in(cfg_live.wide), .phase(phase),
    .strb_exit(strb_exit), .dq_in(dq_in),
    .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .rd_data(rd_data)
  );

  assert_idle_ce_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ce_n);
  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_turn_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> (!dq_oe && re_n && we_n));
  assert_no_drive_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !re_n));
endmodule

// File: tb/nand_phase_seq_test.sv
module nand_phase_seq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tword = '0, cword = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [15:0] req_data = '0;
  logic        rdy_in = 1'b1;
  logic [15:0] dq_in = '0;
  logic        busy, done, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [15:0] rd_data, dq_out;

  int n_vec = 0, n_bad = 0;
  int prev_op = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_phase_seq uut (
    .clk(clk), .rst_n(rst_n), .timing_word(tword), .ctrl_word(cword),
    .req_valid(req_valid), .req_type(req_type), .req_data(req_data),
    .rdy_in(rdy_in), .dq_in(dq_in), .busy(busy), .done(done),
    .rd_data(rd_data), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
    .re_n(re_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input bit en, input bit nand_t, input bit wide,
                                          input bit rdy_en, input int clr, input int alr);
    return (32'(en) << 2) | (32'(nand_t) << 3) | (32'(wide) << 4) | (32'(rdy_en) << 1)
         | (32'(clr & 15) << 9) | (32'(alr & 15) << 13);
  endfunction

  function automatic int atl1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // {busy,ce_n,cle,ale,we_n,re_n,dq_oe,done,dq_out}
  function automatic logic [23:0] exp_vec(input int ph, input int op, input logic [15:0] d,
                                          input bit wide, input bit dn);
    bit act, oe;
    logic [15:0] w;
    act = (ph >= 3);
    oe  = act && (op != 3);
    w   = (op == 2 && wide) ? d : {8'h00, d[7:0]};
    return {ph != 0, ph == 0, act && op == 0, act && op == 1,
            !(ph == 4 && op != 3), !(ph == 4 && op == 3), oe, dn, oe ? w : 16'h0};
  endfunction

  task automatic run_op(input int op, input logic [15:0] data, input logic [15:0] rdval,
                        input int rdy_rel, input int poke_k, input string tag);
    int ts, tw, th, hz, gp, s_s, s_w, s_h, tot, ph;
    bit wide, rdy_en;
    wide   = cword[4];
    rdy_en = cword[1];
    ts = atl1(int'(tword[7:0])) + 1;
    tw = atl1(int'(tword[15:8])) + 1;
    th = atl1(int'(tword[23:16]));
    hz = (op == 3 && prev_op >= 0 && prev_op <= 2) ? int'(tword[31:24]) : 0;
    gp = (op == 3 && prev_op == 0) ? int'(cword[12:9]) + 1 :
         (op == 3 && prev_op == 1) ? int'(cword[16:13]) + 1 : 0;
    s_s = hz + gp;
    s_w = s_s + ts;
    if (rdy_en && rdy_rel - s_w + 1 > tw) tw = rdy_rel - s_w + 1;
    s_h = s_w + tw;
    tot = s_h + th;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(op); req_data = data; rdy_in = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k <= tot; k++) begin
      if (k > 0) @(negedge clk);
      if (k == poke_k) begin
        req_valid = 1'b1; req_type = 2'(op ^ 1);
      end else req_valid = 1'b0;
      rdy_in = (k >= rdy_rel);
      dq_in  = (k == s_h - 1) ? rdval : ~rdval;
      ph = (k < hz) ? 1 : (k < s_s) ? 2 : (k < s_w) ? 3 : (k < s_h) ? 4 : (k < tot) ? 5 : 0;
      chk(tag, {8'h0, busy, ce_n, cle, ale, we_n, re_n, dq_oe, done, dq_out},
          {8'h0, exp_vec(ph, op, data, wide, k == tot)});
      if (k == tot && op == 3)
        chk({tag, " R6 rd_data"}, {16'h0, rd_data},
            {16'h0, wide ? rdval : {8'h00, rdval[7:0]}});
    end
    req_valid = 1'b0;
    rdy_in = 1'b1;
    prev_op = op;
    if (poke_k >= 0) begin
      @(negedge clk);
      chk("R9 request during busy ignored", {31'h0, busy}, 32'h0);
    end
  endtask

  task automatic ignored_req(input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'd2; req_data = 16'hA5A5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {30'h0, busy, ce_n}, 32'h1);
    @(negedge clk);
    chk(tag, {30'h0, busy, ce_n}, 32'h1);
  endtask

  task automatic abort_op(input int op, input int abort_k, input int clear_bit);
    logic [31:0] saved;
    saved = cword;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(op); req_data = 16'h00C3;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < abort_k; k++) @(negedge clk);
    cword[clear_bit] = 1'b0;
    @(negedge clk);
    chk("R10 abort returns idle", {29'h0, busy, ce_n, done}, 32'h2);
    @(negedge clk);
    chk("R10 no done after abort", {29'h0, busy, ce_n, done}, 32'h2);
    cword = saved;
    prev_op = op;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h1D2C3B4A);
    tword = 32'h02_01_02_01;
    cword = mk_ctrl(1, 1, 0, 0, 2, 3);
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 reset outputs", {8'h0, busy, ce_n, cle, ale, we_n, re_n, dq_oe, done, dq_out},
        {8'h0, 8'b0100_1100, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset rd_data", {16'h0, rd_data}, 32'h0);

    // R1 R4: command, address, phase lengths
    run_op(0, 16'hBE70, 16'h0, 0, -1, "R1 R2 R4 command");
    run_op(1, 16'h12_34, 16'h0, 0, -1, "R4 address");
    // R7: read after address uses bits 16:13; R8 turnaround before gap
    tword = 32'h03_02_03_02;
    run_op(3, 16'h0, 16'h5AC3, 0, -1, "R7 R8 read after address");
    // R8: read after read, no turnaround
    run_op(3, 16'h0, 16'h33CC, 0, -1, "R8 read after read");
    // R7: read after command uses bits 12:9, no turnaround when count 0
    tword = 32'h00_01_01_01;
    run_op(0, 16'h0030, 16'h0, 0, -1, "R4 command");
    run_op(3, 16'h0, 16'h0081, 0, -1, "R7 read after command");
    // R5: wide writes and reads
    cword = mk_ctrl(1, 1, 1, 0, 1, 1);
    run_op(2, 16'hC0DE, 16'h0, 0, -1, "R5 R12 wide write");
    run_op(3, 16'h0, 16'hF00D, 0, -1, "R5 R8 wide read after write");
    cword = mk_ctrl(1, 1, 0, 0, 1, 1);
    run_op(2, 16'hC0DE, 16'h0, 0, -1, "R5 narrow write");
    // R3: zero counts behave as 1
    tword = 32'h00_00_00_00;
    run_op(2, 16'h0077, 16'h0, 0, -1, "R3 zero counts");
    tword = 32'h00_01_01_01;
    run_op(2, 16'h0077, 16'h0, 0, -1, "R3 count one");
    // R11: ready input stretches the strobe
    tword = 32'h00_01_01_01;
    cword = mk_ctrl(1, 1, 0, 1, 0, 0);
    run_op(2, 16'h0011, 16'h0, 9, -1, "R11 ready stall");
    cword = mk_ctrl(1, 1, 0, 0, 0, 0);
    run_op(2, 16'h0022, 16'h0, 9, -1, "R11 ready ignored");
    // R9: requests during busy ignored
    tword = 32'h00_02_03_02;
    run_op(1, 16'h0044, 16'h0, 0, 2, "R9 poke address");
    run_op(2, 16'h0055, 16'h0, 0, 6, "R9 poke late");
    // R10: enable and device type gate requests
    cword = mk_ctrl(0, 1, 0, 0, 0, 0);
    ignored_req("R10 disabled bank");
    cword = mk_ctrl(1, 0, 0, 0, 0, 0);
    ignored_req("R10 not nand type");
    cword = mk_ctrl(1, 1, 0, 0, 0, 0);
    abort_op(2, 3, 2);
    abort_op(0, 1, 3);
    // longer counts
    tword = 32'h05_0C_14_10;
    run_op(3, 16'h0, 16'h00E7, 0, -1, "R1 R8 long read after command");

    // random mix
    for (int i = 0; i < 60; i++) begin
      int op, rr;
      bit rdy_en;
      op = int'($urandom % 4);
      rdy_en = bit'($urandom % 2);
      tword = {8'($urandom % 4), 8'($urandom % 5), 8'($urandom % 5), 8'($urandom % 5)};
      cword = mk_ctrl(1, 1, bit'($urandom % 2), rdy_en, int'($urandom % 4), int'($urandom % 4));
      rr = rdy_en ? int'($urandom % 12) : 0;
      run_op(op, 16'($urandom), 16'($urandom), rr, -1, "R1 R7 R8 R12 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule